// File: doc/BRIEF.md
# Multiprocessor UART Address Filter

This block sits behind the receive deserializer of a UART that shares one line with several nodes using 9-bit frames. Each received character has eight data bits and a ninth flag bit, which replaces the parity bit. When that flag is 1, the character is an address frame. When it is 0, the character is a data frame. The filter compares every address frame against this node's programmed address and keeps a one-bit "selected" state. Data frames reach the host only while that state is set. Traffic for other nodes is therefore discarded without the host doing any work.

Two configuration inputs choose the behaviour. With multiprocessor filtering off, every character is forwarded unchanged. With filtering on and address pass-through off, the selection is made entirely in hardware, and address frames themselves never reach the host. With address pass-through on, every address frame is also forwarded to the host and marked as an address. Software can then apply its own decision on top of the hardware match.

Each accepted character appears one clock after it arrives, as a single-cycle valid pulse. The pulse comes with the data byte and an address flag.

Top module: `mp_addr_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and the selected state is clear. A data frame that arrives after reset with filtering on is therefore not forwarded.
- R2: When `mp_en` is 0, every input character appears at the output one cycle later. `out_data` equals the input byte, and `out_is_addr` equals the input's ninth bit.
- R3: With `mp_en` at 1, an address frame (ninth bit 1) whose byte equals `node_addr` sets the selected state. Each later data frame (ninth bit 0) is then forwarded one cycle after it arrives, with `out_is_addr` at 0.
- R4: With `mp_en` at 1, an address frame whose byte differs from `node_addr` clears the selected state. Later data frames produce no `out_valid`.
- R5: With `mp_en` at 1 and `addr_pass` at 0, address frames never produce `out_valid`.
- R6: With `mp_en` at 1 and `addr_pass` at 1, every address frame is forwarded one cycle later with `out_is_addr` at 1 and its byte on `out_data`, whether or not it matches.
- R7: Any cycle with `mp_en` at 0 clears the selected state. A data frame that follows once filtering is back on is dropped until a matching address arrives.
- R8: `out_valid` is high for exactly one cycle per accepted character, and only in the cycle right after an `in_valid` cycle.
- R9: While `out_valid` is 0, `out_data` and `out_is_addr` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mp_en | input | 1 | Enables multiprocessor filtering |
| addr_pass | input | 1 | Forwards every address frame to the host |
| node_addr | input | DATA_W | This node's address |
| in_valid | input | 1 | Received character strobe |
| in_data | input | DATA_W | Received byte |
| in_mp | input | 1 | Received ninth bit (1 = address frame) |
| out_valid | output | 1 | Delivered character strobe |
| out_data | output | DATA_W | Delivered byte |
| out_is_addr | output | 1 | Delivered character was an address frame |

## Verification
Every result appears exactly one clock after the input cycle that causes it. The selected state changes at the same edge, so it affects the next character and never the one that changed it. The bench drives a character on a falling edge and samples the outputs on the following falling edge, after the single register stage has updated. It keeps a model of the selected state that it updates only after each frame's expected result has been computed. Idle gaps between frames are used to check that the output is held and that no stray pulse appears.

// File: rtl/mp_addr_filter.sv
module mp_addr_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mp_en,
  input  logic              addr_pass,
  input  logic [DATA_W-1:0] node_addr,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_mp,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_is_addr
);

  logic selected;
  logic hit;
  logic take;

  assign hit  = (in_data == node_addr);
  assign take = in_valid && (!mp_en || (in_mp ? addr_pass : selected));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selected <= 1'b0;
    end else if (!mp_en) begin
      selected <= 1'b0;
    end else if (in_valid && in_mp) begin
      selected <= hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_is_addr <= 1'b0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_data    <= in_data;
        out_is_addr <= in_mp;
      end
    end
  end

  // R8
  valid_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R2
  bypass_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mp_en) |=> (out_valid && out_data == $past(in_data) && out_is_addr == $past(in_mp)));

  // R5
  addr_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mp_en && in_mp && !addr_pass) |=> !out_valid);

  // R6
  addr_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mp_en && in_mp && addr_pass) |=> (out_valid && out_is_addr));

  // R4
  mismatch_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && mp_en && in_mp && (in_data != node_addr)) && in_valid && mp_en && !in_mp)
    |=> !out_valid);

  // R3
  match_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && mp_en && in_mp && (in_data == node_addr)) && in_valid && mp_en && !in_mp)
    |=> (out_valid && !out_is_addr));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_data) && $stable(out_is_addr)));

endmodule

// File: tb/mp_addr_filter_test.sv
module mp_addr_filter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mp_en = 1'b0;
  logic       addr_pass = 1'b0;
  logic [7:0] node_addr = 8'h00;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_mp = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_is_addr;

  int checks = 0;
  int fails = 0;
  bit sel_model = 1'b0;
  logic [7:0] last_data = 8'h00;
  logic       last_flag = 1'b0;

  always #5 clk = ~clk;

  mp_addr_filter #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .mp_en(mp_en), .addr_pass(addr_pass),
    .node_addr(node_addr), .in_valid(in_valid), .in_data(in_data), .in_mp(in_mp),
    .out_valid(out_valid), .out_data(out_data), .out_is_addr(out_is_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] d, input logic m, input string req);
    bit exp_v;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_mp = m;
    exp_v = !mp_en || (m ? addr_pass : sel_model);
    if (!mp_en) sel_model = 1'b0;
    else if (m) sel_model = (d == node_addr);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, out_valid, exp_v);
    if (exp_v) begin
      chk({req, " data"}, out_data, d);
      chk({req, " flag"}, out_is_addr, m);
      last_data = d; last_flag = m;
    end else begin
      chk({req, " hold data (R9)"}, out_data, last_data);
      chk({req, " hold flag (R9)"}, out_is_addr, last_flag);
    end
    @(negedge clk);
    chk({req, " single pulse (R8)"}, out_valid, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    node_addr = 8'h3C;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", out_valid, 0);
    rst_n = 1'b1;
    mp_en = 1'b1;
    @(negedge clk);
    chk("R1 post-reset valid", out_valid, 0);
    frame(8'hA5, 1'b0, "R1 data after reset");

    mp_en = 1'b0;
    for (int i = 0; i < 512; i++) frame(i[7:0], i[8], "R2 bypass");

    for (int p = 0; p < 2; p++) begin
      mp_en = 1'b1;
      addr_pass = p[0];
      for (int a = 0; a < 256; a++) begin
        frame(a[7:0], 1'b1, p[0] ? "R6 addr frame" : "R5 addr frame");
        frame(a[7:0] ^ 8'h5A, 1'b0, (a == 8'h3C) ? "R3 data after match" : "R4 data after miss");
        frame(8'hFF, 1'b0, (a == 8'h3C) ? "R3 second data" : "R4 second data");
      end
    end

    addr_pass = 1'b0;
    frame(8'h3C, 1'b1, "R3 select");
    frame(8'h11, 1'b0, "R3 selected data");
    @(negedge clk); mp_en = 1'b0;
    @(negedge clk); mp_en = 1'b1; sel_model = 1'b0;
    chk("R7 idle valid", out_valid, 0);
    frame(8'h22, 1'b0, "R7 data after disable");
    frame(8'h3C, 1'b1, "R7 reselect");
    frame(8'h33, 1'b0, "R7 data after reselect");

    node_addr = 8'h00;
    frame(8'h00, 1'b1, "R3 zero address");
    frame(8'h44, 1'b0, "R3 zero address data");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule